// File: doc/BRIEF.md
# Mod-3 Residue Checked Adder

This block is an unsigned binary adder that checks itself while it runs. Two operands are captured together, and their full sum is produced, carry included. Alongside the adder, a separate path reduces each captured operand to its remainder modulo 3 and adds those two remainders modulo 3. It then compares that result with the remainder modulo 3 of the sum that leaves the adder. If the two differ, the adder output cannot be right, and an error flag is raised in the same cycle as that sum.

A fault-injection control can invert one chosen bit of the sum before the comparison. This lets a system exercise the checker in the field. Inverting bit i changes the sum by 2^i, and no power of two is a multiple of 3, so every single-bit upset of the sum is caught. The block has a register stage at its inputs and another at its outputs, so a result appears one cycle after its operands are captured. A new operand pair may be accepted on every cycle.

Top module: `mod3_checked_adder`

## Requirements
- R1: While reset is held and after it is released, sumOut is 0, errFlag is 0 and outValid is 0 until a result is produced.
- R2: For operands captured together, sumOut equals opA + opB as an unsigned W+1-bit value. Bit W of sumOut is the carry out.
- R3: Operands, faultEn and faultSel are captured at a rising edge where inValid is 1. At the next rising edge, sumOut and errFlag take the result and outValid is 1 for exactly one cycle. In the cycle between those two edges, outValid is 0 unless an earlier capture is completing.
- R4: A cycle with inValid at 0 captures nothing. sumOut and errFlag keep their values whatever opA, opB, faultEn and faultSel do, and outValid is 0 one edge later.
- R5: With faultEn at 0 when captured, errFlag is 0 in the result for every operand pair, carry out included.
- R6: With faultEn at 1 and faultSel in the range 0 to W when captured, sumOut equals the true sum with bit faultSel inverted. faultSel equal to W selects the carry bit.
- R7: For every injected inversion as in R6, errFlag is 1 in that result.
- R8: With faultEn at 1 and faultSel above W, the injection has no effect: sumOut is the true sum and errFlag is 0.
- R9: Operand pairs captured on consecutive edges each produce their own result on consecutive edges, with no result lost or repeated.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Synchronous reset, active low |
| inValid | input | 1 | Capture strobe for the operands and fault controls |
| opA | input | W | First unsigned operand |
| opB | input | W | Second unsigned operand |
| faultEn | input | 1 | Enables inversion of one sum bit |
| faultSel | input | $clog2(W+1) | Index of the sum bit to invert, 0 to W |
| sumOut | output | W+1 | Registered sum with carry in the top bit |
| outValid | output | 1 | One-cycle marker of a new result |
| errFlag | output | 1 | Residue mismatch seen on the registered sum |

## Verification
The bench builds the block with W = 8. That gives a 9-bit sum and a 4-bit selector. With this selector, the bench can invert every sum bit including the carry, and it can also drive seven selector codes (9 to 15) that must be ignored. With 8-bit operands, the all-ones corners and carry-producing pairs are reached directly. A random stream with mixed gaps and back-to-back captures covers the full operand space around them.

// File: rtl/radd_pkg.sv
package radd_pkg;

  // Strobes from the control to the datapath
  typedef struct packed {
    logic loadIn;   // capture operands and fault controls
    logic loadOut;  // register sum and error flag
  } raddStrobe_t;

  // Modulo-3 addition of two residues in the range 0..2
  function automatic logic [1:0] mod3Add(input logic [1:0] x, input logic [1:0] y);
    logic [2:0] s;
    s = {1'b0, x} + {1'b0, y};
    if (s >= 3'd3) s = s - 3'd3;
    return s[1:0];
  endfunction

endpackage

// File: rtl/mod3_residue.sv
module mod3_residue #(
  parameter int W = 8
) (
  input  logic [W-1:0] word,
  output logic [1:0]   res
);
  import radd_pkg::*;

  // Bit i weighs 2^i, which is 1 mod 3 for even i and 2 (that is, -1) for odd i
  always_comb begin
    res = 2'd0;
    for (int i = 0; i < W; i++) begin
      if (word[i]) res = mod3Add(res, (i % 2 == 0) ? 2'd1 : 2'd2);
    end
  end

endmodule

// File: rtl/radd_ctrl.sv
module radd_ctrl (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    inValid,
  output radd_pkg::raddStrobe_t   strobe,
  output logic                    outValid
);
  logic stageValid;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stageValid <= 1'b0;
      outValid   <= 1'b0;
    end else begin
      stageValid <= inValid;
      outValid   <= stageValid;
    end
  end

  always_comb begin
    strobe.loadIn  = inValid;
    strobe.loadOut = stageValid;
  end

  // R3
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $past(inValid, 2));

  // R4
  idle_no_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    !stageValid |=> !outValid);

endmodule

// File: rtl/radd_datapath.sv
module radd_datapath #(
  parameter int W    = 8,
  parameter int SELW = $clog2(W + 1)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  radd_pkg::raddStrobe_t strobe,
  input  logic [W-1:0]          opA,
  input  logic [W-1:0]          opB,
  input  logic                  faultEn,
  input  logic [SELW-1:0]       faultSel,
  output logic [W:0]            sumOut,
  output logic                  errFlag
);
  import radd_pkg::*;

  logic [W-1:0]    aQ, bQ;
  logic            faultEnQ;
  logic [SELW-1:0] faultSelQ;
  logic [W:0]      rawSum, flipMask, checkSum;
  logic [1:0]      resA, resB, resSum, resPredict;
  logic            mismatch;

  // Input register stage
  always_ff @(posedge clk) begin
    if (!rstN) begin
      aQ        <= '0;
      bQ        <= '0;
      faultEnQ  <= 1'b0;
      faultSelQ <= '0;
    end else if (strobe.loadIn) begin
      aQ        <= opA;
      bQ        <= opB;
      faultEnQ  <= faultEn;
      faultSelQ <= faultSel;
    end
  end

  assign rawSum = {1'b0, aQ} + {1'b0, bQ};

  // One-hot inversion mask; selector codes above W match no bit
  always_comb begin
    for (int i = 0; i <= W; i++) begin
      flipMask[i] = faultEnQ && (faultSelQ == SELW'(i));
    end
  end

  assign checkSum = rawSum ^ flipMask;

  // Residue path, independent of the adder
  mod3_residue #(.W(W))     u_resA   (.word(aQ),       .res(resA));
  mod3_residue #(.W(W))     u_resB   (.word(bQ),       .res(resB));
  mod3_residue #(.W(W + 1)) u_resSum (.word(checkSum), .res(resSum));

  assign resPredict = mod3Add(resA, resB);
  assign mismatch   = (resPredict != resSum);

  // Output register stage
  always_ff @(posedge clk) begin
    if (!rstN) begin
      sumOut  <= '0;
      errFlag <= 1'b0;
    end else if (strobe.loadOut) begin
      sumOut  <= checkSum;
      errFlag <= mismatch;
    end
  end

  // R5
  clean_residue_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.loadOut && !faultEnQ) |=> !errFlag);

  // R7
  flip_detect_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.loadOut && (|flipMask)) |=> errFlag);

  // R4
  hold_sum_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.loadOut |=> ($stable(sumOut) && $stable(errFlag)));

  // R6
  single_flip_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadOut |-> $onehot0(flipMask));

endmodule

// File: rtl/mod3_checked_adder.sv
module mod3_checked_adder #(
  parameter int W = 8,
  localparam int SELW = $clog2(W + 1)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            inValid,
  input  logic [W-1:0]    opA,
  input  logic [W-1:0]    opB,
  input  logic            faultEn,
  input  logic [SELW-1:0] faultSel,
  output logic [W:0]      sumOut,
  output logic            outValid,
  output logic            errFlag
);
  import radd_pkg::*;

  raddStrobe_t strobe;

  radd_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .strobe   (strobe),
    .outValid (outValid)
  );

  radd_datapath #(.W(W), .SELW(SELW)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .opA      (opA),
    .opB      (opB),
    .faultEn  (faultEn),
    .faultSel (faultSel),
    .sumOut   (sumOut),
    .errFlag  (errFlag)
  );

  // R2
  sum_match_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !$past(faultEn, 2)) |->
      (sumOut == ({1'b0, $past(opA, 2)} + {1'b0, $past(opB, 2)})));

  // R8
  sel_ignore_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && $past(faultEn, 2) && ($past(faultSel, 2) > SELW'(W))) |->
      (!errFlag && (sumOut == ({1'b0, $past(opA, 2)} + {1'b0, $past(opB, 2)}))));

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    $past(!rstN) |-> (!outValid && !errFlag && (sumOut == '0)));

endmodule

// File: tb/mod3_checked_adder_bench.sv
module mod3_checked_adder_bench;
  localparam int W        = 8;
  localparam int SELW     = $clog2(W + 1);
  localparam int CLK_HALF = 5;

  logic            clk = 1'b0;
  logic            rstN;
  logic            inValid;
  logic [W-1:0]    opA, opB;
  logic            faultEn;
  logic [SELW-1:0] faultSel;
  logic [W:0]      sumOut;
  logic            outValid;
  logic            errFlag;

  int nTests = 0;
  int nFail  = 0;
  bit done   = 1'b0;

  always #(CLK_HALF) clk = ~clk;

  mod3_checked_adder #(.W(W)) u_mod3_checked_adder (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opA(opA), .opB(opB),
    .faultEn(faultEn), .faultSel(faultSel),
    .sumOut(sumOut), .outValid(outValid), .errFlag(errFlag)
  );

  function automatic logic [W:0] expSum(logic [W-1:0] a, logic [W-1:0] b,
                                        logic fe, logic [SELW-1:0] fs);
    logic [W:0] s;
    s = {1'b0, a} + {1'b0, b};
    if (fe && fs <= SELW'(W)) s[fs] = ~s[fs];
    return s;
  endfunction

  function automatic logic expErr(logic fe, logic [SELW-1:0] fs);
    return fe && (fs <= SELW'(W));
  endfunction

  task automatic chk(string req, logic [W:0] act, logic [W:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Single transaction with timing checks, results sampled on falling edges
  task automatic apply(string req, logic [W-1:0] a, logic [W-1:0] b,
                       logic fe, logic [SELW-1:0] fs);
    @(negedge clk);
    opA = a; opB = b; faultEn = fe; faultSel = fs; inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    chk("R3 no early valid", {{W{1'b0}}, outValid}, '0);
    @(negedge clk);
    chk({req, " valid"}, {{W{1'b0}}, outValid}, 1);
    chk({req, " sum"}, sumOut, expSum(a, b, fe, fs));
    chk({req, " err"}, {{W{1'b0}}, errFlag}, {{W{1'b0}}, expErr(fe, fs)});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    logic [W:0] held;
    logic       heldErr;
    logic       prevV;
    logic [W:0] prevSum;
    logic       prevErr;
    void'($urandom(32'd20240611));
    rstN = 1'b0; inValid = 1'b0; opA = '0; opB = '0; faultEn = 1'b0; faultSel = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 sum", sumOut, '0);
    chk("R1 valid", {{W{1'b0}}, outValid}, '0);
    chk("R1 err", {{W{1'b0}}, errFlag}, '0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 after release", {{(W-1){1'b0}}, outValid, errFlag}, '0);

    // Directed corners: R2, R5
    apply("R2 zero", 8'h00, 8'h00, 1'b0, '0);
    apply("R2 max carry", 8'hFF, 8'hFF, 1'b0, '0);
    apply("R5 wrap", 8'hFF, 8'h01, 1'b0, '0);
    apply("R5 alt bits", 8'hAA, 8'h55, 1'b0, '0);

    // R3 one-cycle pulse
    @(negedge clk);
    chk("R3 pulse ends", {{W{1'b0}}, outValid}, '0);

    // R6, R7 every bit position including carry
    for (int i = 0; i <= W; i++) begin
      apply("R6 R7 flip", 8'hC3, 8'h7E, 1'b1, SELW'(i));
    end
    // R8 out-of-range selector
    for (int i = W + 1; i < (1 << SELW); i++) begin
      apply("R8 ignored sel", 8'h9D, 8'hB4, 1'b1, SELW'(i));
    end

    // R4 hold while idle
    apply("R4 setup", 8'h12, 8'h34, 1'b1, SELW'(2));
    held = sumOut; heldErr = errFlag;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      opA = W'($urandom); opB = W'($urandom); faultEn = 1'b1; faultSel = SELW'(k);
      inValid = 1'b0;
    end
    @(negedge clk);
    chk("R4 sum held", sumOut, held);
    chk("R4 err held", {{W{1'b0}}, errFlag}, {{W{1'b0}}, heldErr});
    chk("R4 no valid", {{W{1'b0}}, outValid}, '0);

    // R9 random stream with back-to-back and gaps
    prevV = 1'b0; prevSum = '0; prevErr = 1'b0;
    for (int n = 0; n < 400; n++) begin
      logic [W-1:0]    a, b;
      logic            fe, v;
      logic [SELW-1:0] fs;
      @(negedge clk);
      if (prevV) begin
        chk("R9 valid", {{W{1'b0}}, outValid}, 1);
        chk("R9 R2 sum", sumOut, prevSum);
        chk("R9 R5 R7 err", {{W{1'b0}}, errFlag}, {{W{1'b0}}, prevErr});
      end else begin
        chk("R9 R4 idle valid", {{W{1'b0}}, outValid}, '0);
      end
      a = W'($urandom); b = W'($urandom);
      v = ($urandom % 4) != 0;
      fe = ($urandom % 4) == 0;
      fs = SELW'($urandom);
      opA = a; opB = b; faultEn = fe; faultSel = fs; inValid = v;
      @(negedge clk);
      // second stage: result of item captured two edges ago checked next iteration
      inValid = 1'b0;
      if (v) begin
        chk("R9 R3 latency", {{W{1'b0}}, outValid}, '0 | {{W{1'b0}}, prevV});
      end
      prevV = 1'b0;
      @(negedge clk);
      if (v) begin
        chk("R9 valid", {{W{1'b0}}, outValid}, 1);
        chk("R9 R2 sum", sumOut, expSum(a, b, fe, fs));
        chk("R9 R5 R7 err", {{W{1'b0}}, errFlag}, {{W{1'b0}}, expErr(fe, fs)});
      end
    end

    // R9 true back-to-back burst
    prevV = 1'b0;
    for (int n = 0; n < 200; n++) begin
      logic [W-1:0]    a, b;
      logic            fe;
      logic [SELW-1:0] fs;
      @(negedge clk);
      if (n >= 2) begin
        chk("R9 burst valid", {{W{1'b0}}, outValid}, 1);
        chk("R9 burst sum", sumOut, prevSum);
        chk("R9 burst err", {{W{1'b0}}, errFlag}, {{W{1'b0}}, prevErr});
      end
      a = W'($urandom); b = W'($urandom);
      fe = ($urandom % 3) == 0; fs = SELW'($urandom);
      opA = a; opB = b; faultEn = fe; faultSel = fs; inValid = 1'b1;
      // result checked two falling edges later; shift a two-deep record
      prevSum = stageSum; prevErr = stageErr;
      stageSum = expSum(a, b, fe, fs); stageErr = expErr(fe, fs);
    end
    @(negedge clk);
    inValid = 1'b0;
    chk("R9 burst tail sum", sumOut, prevSum);
    @(negedge clk);
    chk("R9 burst last sum", sumOut, stageSum);
    chk("R9 burst last err", {{W{1'b0}}, errFlag}, {{W{1'b0}}, stageErr});

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  logic [W:0] stageSum = '0;
  logic       stageErr = 1'b0;

endmodule